// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the eight-bit status word that an I2C controller shows to its host. The bus engine sends it single-cycle event pulses: a start condition generated by this controller, a start condition seen on the bus, a stop condition seen on the bus, a lost arbitration, a request to leave the current transfer, and the falling edge of the controller enable. The engine also drives six level flags (extension code, address match, transmit direction, acknowledge seen, start seen, stop seen). The block registers these into the status word once per cycle. It keeps the master-status and arbitration-lost flags itself. The master-status flag is set and cleared by the events. The arbitration-lost flag is set by a lost arbitration and cleared by host accesses.

The host side is a read strobe with a single-bit qualifier, a three-bit bit select, and a read-window input. The read-window input is high while the start-trigger control is set and the engine is in a wait period. A wakeup-mode level input drives a small state machine with three states: `ST_RUN`, `ST_WAKE` and `ST_HOLD`. When wakeup mode is turned off, the visible status word is frozen. Events go on updating a live copy in the background. That copy is moved into the visible word in the cycle the next start or stop condition is detected.

The state machine has these transitions:
- `ST_RUN` to `ST_WAKE` when wakeup is enabled.
- `ST_WAKE` to `ST_HOLD` when wakeup is disabled and no start or stop is seen in that cycle.
- `ST_WAKE` to `ST_RUN` when wakeup is disabled and a start or stop is seen in that cycle.
- `ST_HOLD` to `ST_WAKE` or to `ST_RUN`, chosen by the wakeup level, on a start or stop detection.

In all other cases the machine stays in its state.

Top module: `i2c_sts_reg`

## Requirements
- R1: The status byte carries, from bit 7 to bit 0: master-status, arbitration-lost, extension code, address match, transmit mode, acknowledge seen, start seen, stop seen. `eng_flags[5:0]` maps to status bits 5 to 0 in that order.
- R2: While reset is low the status byte reads 0x00, whatever the other inputs do.
- R3: A start-generated pulse, with no clearing event in the same cycle, sets master-status on the next clock edge.
- R4: Master-status is cleared by any of: stop detected, arbitration lost, exit request, enable falling. A clearing event wins over a start-generated pulse in the same cycle.
- R5: An arbitration-lost pulse sets arbitration-lost (bit 6) and clears master-status (bit 7) on the next edge.
- R6: Arbitration-lost is cleared by a permitted read of the status: a byte read (`rd_bit`=0), or a single-bit read with `rd_sel`=6, while `rd_ok`=1. It is also cleared by an enable-falling pulse. An arbitration-lost pulse in the same cycle as a clear keeps the flag at 1.
- R7: A single-bit access (`rd_stb`=1, `rd_bit`=1) with `rd_sel` other than 6 clears arbitration-lost even when `rd_ok`=0.
- R8: A byte read, or a bit-6 read, with `rd_ok`=0 leaves arbitration-lost unchanged.
- R9: `status[5:0]` takes the value of `eng_flags` one clock after it is applied. There is no path from `eng_flags` to the outputs that bypasses the register.
- R10: When wakeup mode goes from 1 to 0, the status byte stays frozen from the next cycle until a start or stop detection. Events and engine flags in that interval do not change the visible status.
- R11: In the cycle a start or stop is detected in the frozen interval, the status byte takes the live copy. That copy includes all events and flags up to and including that cycle. After that, updates are again applied every cycle.
- R12: Each of the eight per-flag outputs equals its bit of the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_start_gen | input | 1 | Pulse: this controller generated a start condition |
| ev_start_det | input | 1 | Pulse: start condition detected on the bus |
| ev_stop_det | input | 1 | Pulse: stop condition detected on the bus |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_exit | input | 1 | Pulse: request to leave the current transfer |
| ev_en_fall | input | 1 | Pulse: controller enable went from 1 to 0 |
| eng_flags | input | 6 | Engine level flags for status bits 5..0 |
| rd_stb | input | 1 | Host access strobe on the status register |
| rd_bit | input | 1 | 1 = single-bit access, 0 = byte read |
| rd_sel | input | 3 | Bit position addressed by a single-bit access |
| rd_ok | input | 1 | Read window open (start trigger set and wait period) |
| wake_en | input | 1 | Wakeup mode enable level |
| status | output | 8 | Visible status byte |
| flag_mst | output | 1 | Master-status flag |
| flag_ald | output | 1 | Arbitration-lost flag |
| flag_ext | output | 1 | Extension code flag |
| flag_match | output | 1 | Address match flag |
| flag_xmit | output | 1 | Transmit mode flag |
| flag_ack | output | 1 | Acknowledge seen flag |
| flag_std | output | 1 | Start seen flag |
| flag_spd | output | 1 | Stop seen flag |

## Verification
The hardest case to reach is the deferred interval. The bench first has to enter `ST_WAKE`, then drop the wakeup level so the machine lands in `ST_HOLD`, and only then apply events and new engine flags that must stay invisible. In that interval it pulses start-generated in one pass, and arbitration-lost plus new flags in another. It then closes the interval once with a start detection and once with a stop detection. The checks confirm that the released byte holds the accumulated events, and that the flag clearing done by the closing stop is applied in that same cycle.

// File: rtl/i2c_sts_pkg.sv
package i2c_sts_pkg;

    localparam int STS_W   = 8;
    localparam int ENG_W   = STS_W - 2;
    localparam int SEL_W   = $clog2(STS_W);

    localparam int BIT_MST = STS_W - 1;
    localparam int BIT_ALD = STS_W - 2;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAKE = 2'd1,
        ST_HOLD = 2'd2
    } defer_st_t;

endpackage

// File: rtl/i2c_sts_defer_fsm.sv
module i2c_sts_defer_fsm
    import i2c_sts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wake_en,
    input  logic cond_det,
    output logic apply_upd,
    output logic hold_act
);

    defer_st_t state_q;
    defer_st_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wake_en) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (!wake_en) state_d = cond_det ? ST_RUN : ST_HOLD;
            end
            ST_HOLD: begin
                if (cond_det) state_d = wake_en ? ST_WAKE : ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        apply_upd = 1'b1;
        hold_act  = 1'b0;
        unique case (state_q)
            ST_RUN:  apply_upd = 1'b1;
            ST_WAKE: apply_upd = 1'b1;
            ST_HOLD: begin
                hold_act  = 1'b1;
                apply_upd = cond_det;
            end
            default: apply_upd = 1'b1;
        endcase
    end

endmodule

// File: rtl/i2c_sts_mst_ald.sv
module i2c_sts_mst_ald
    import i2c_sts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_gen,
    input  logic             stop_det,
    input  logic             arb_lost,
    input  logic             exit_rq,
    input  logic             en_fall,
    input  logic             rd_stb,
    input  logic             rd_bit,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic             rd_ok,
    output logic             mst_nxt,
    output logic             ald_nxt
);

    logic mst_q;
    logic ald_q;
    logic mst_clr;
    logic sel_is_ald;
    logic rd_clr;

    assign sel_is_ald = (rd_sel == SEL_W'(BIT_ALD));
    assign mst_clr    = stop_det | arb_lost | exit_rq | en_fall;
    // permitted read of the word or of the flag itself, or bit access elsewhere
    assign rd_clr     = rd_stb & ((rd_ok & (!rd_bit | sel_is_ald)) |
                                  (rd_bit & !sel_is_ald));

    always_comb begin
        mst_nxt = mst_q;
        if (mst_clr)        mst_nxt = 1'b0;
        else if (start_gen) mst_nxt = 1'b1;
    end

    always_comb begin
        ald_nxt = ald_q;
        if (arb_lost)               ald_nxt = 1'b1;
        else if (en_fall || rd_clr) ald_nxt = 1'b0;
    end

    // live copy, keeps running while the visible word is frozen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_q <= 1'b0;
            ald_q <= 1'b0;
        end else begin
            mst_q <= mst_nxt;
            ald_q <= ald_nxt;
        end
    end

endmodule

// File: rtl/i2c_sts_vis_bank.sv
module i2c_sts_vis_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         apply_upd,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] vis
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vis[i] <= 1'b0;
            end else if (apply_upd) begin
                vis[i] <= nxt[i];
            end
        end
    end

endmodule

// File: rtl/i2c_sts_reg.sv
module i2c_sts_reg
    import i2c_sts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start_gen,
    input  logic             ev_start_det,
    input  logic             ev_stop_det,
    input  logic             ev_arb_lost,
    input  logic             ev_exit,
    input  logic             ev_en_fall,
    input  logic [ENG_W-1:0] eng_flags,
    input  logic             rd_stb,
    input  logic             rd_bit,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic             rd_ok,
    input  logic             wake_en,
    output logic [STS_W-1:0] status,
    output logic             flag_mst,
    output logic             flag_ald,
    output logic             flag_ext,
    output logic             flag_match,
    output logic             flag_xmit,
    output logic             flag_ack,
    output logic             flag_std,
    output logic             flag_spd
);

    logic             apply_upd;
    logic             hold_act;
    logic             mst_nxt;
    logic             ald_nxt;
    logic [STS_W-1:0] sts_nxt;

    i2c_sts_defer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_en   (wake_en),
        .cond_det  (ev_start_det | ev_stop_det),
        .apply_upd (apply_upd),
        .hold_act  (hold_act)
    );

    i2c_sts_mst_ald u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_gen (ev_start_gen),
        .stop_det  (ev_stop_det),
        .arb_lost  (ev_arb_lost),
        .exit_rq   (ev_exit),
        .en_fall   (ev_en_fall),
        .rd_stb    (rd_stb),
        .rd_bit    (rd_bit),
        .rd_sel    (rd_sel),
        .rd_ok     (rd_ok),
        .mst_nxt   (mst_nxt),
        .ald_nxt   (ald_nxt)
    );

    assign sts_nxt = {mst_nxt, ald_nxt, eng_flags};

    i2c_sts_vis_bank #(.W(STS_W)) u_vis (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply_upd (apply_upd),
        .nxt       (sts_nxt),
        .vis       (status)
    );

    assign flag_mst   = status[BIT_MST];
    assign flag_ald   = status[BIT_ALD];
    assign flag_ext   = status[5];
    assign flag_match = status[4];
    assign flag_xmit  = status[3];
    assign flag_ack   = status[2];
    assign flag_std   = status[1];
    assign flag_spd   = status[0];

endmodule

// File: rtl/i2c_sts_checker.sv
module i2c_sts_checker
    import i2c_sts_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ev_start_gen,
    input logic             ev_start_det,
    input logic             ev_stop_det,
    input logic             ev_arb_lost,
    input logic             ev_exit,
    input logic             ev_en_fall,
    input logic             rd_stb,
    input logic             rd_bit,
    input logic             rd_ok,
    input logic             hold_act,
    input logic [STS_W-1:0] status
);

    logic any_clr;
    assign any_clr = ev_stop_det | ev_arb_lost | ev_exit | ev_en_fall;

    assert_reset_zero_R2: assert property (@(posedge clk)
        !rst_n |=> (status == '0));

    assert_mst_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start_gen && !any_clr && (!hold_act || ev_start_det))
        |=> status[BIT_MST]);

    assert_mst_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_act && any_clr) |=> !status[BIT_MST]);

    assert_arb_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_act && ev_arb_lost) |=> (status[BIT_ALD] && !status[BIT_MST]));

    assert_closed_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_act && rd_stb && !rd_bit && !rd_ok && !ev_arb_lost && !ev_en_fall)
        |=> (status[BIT_ALD] == $past(status[BIT_ALD])));

    assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_act && !ev_start_det && !ev_stop_det) |=> $stable(status));

endmodule

bind i2c_sts_reg i2c_sts_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_start_gen (ev_start_gen),
    .ev_start_det (ev_start_det),
    .ev_stop_det  (ev_stop_det),
    .ev_arb_lost  (ev_arb_lost),
    .ev_exit      (ev_exit),
    .ev_en_fall   (ev_en_fall),
    .rd_stb       (rd_stb),
    .rd_bit       (rd_bit),
    .rd_ok        (rd_ok),
    .hold_act     (hold_act),
    .status       (status)
);

// File: tb/test_i2c_sts_reg.sv
module test_i2c_sts_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start_gen = 1'b0;
    logic       ev_start_det = 1'b0;
    logic       ev_stop_det = 1'b0;
    logic       ev_arb_lost = 1'b0;
    logic       ev_exit = 1'b0;
    logic       ev_en_fall = 1'b0;
    logic [5:0] eng_flags = 6'h00;
    logic       rd_stb = 1'b0;
    logic       rd_bit = 1'b0;
    logic [2:0] rd_sel = 3'd0;
    logic       rd_ok = 1'b0;
    logic       wake_en = 1'b0;
    logic [7:0] status;
    logic       flag_mst, flag_ald, flag_ext, flag_match;
    logic       flag_xmit, flag_ack, flag_std, flag_spd;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    i2c_sts_reg i_i2c_sts_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_start_gen (ev_start_gen),
        .ev_start_det (ev_start_det),
        .ev_stop_det  (ev_stop_det),
        .ev_arb_lost  (ev_arb_lost),
        .ev_exit      (ev_exit),
        .ev_en_fall   (ev_en_fall),
        .eng_flags    (eng_flags),
        .rd_stb       (rd_stb),
        .rd_bit       (rd_bit),
        .rd_sel       (rd_sel),
        .rd_ok        (rd_ok),
        .wake_en      (wake_en),
        .status       (status),
        .flag_mst     (flag_mst),
        .flag_ald     (flag_ald),
        .flag_ext     (flag_ext),
        .flag_match   (flag_match),
        .flag_xmit    (flag_xmit),
        .flag_ack     (flag_ack),
        .flag_std     (flag_std),
        .flag_spd     (flag_spd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // one clock: inputs were set at a falling edge, result sampled at the next one
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        ev_start_gen = 1'b0; ev_start_det = 1'b0; ev_stop_det = 1'b0;
        ev_arb_lost = 1'b0;  ev_exit = 1'b0;      ev_en_fall = 1'b0;
        rd_stb = 1'b0; rd_bit = 1'b0; rd_sel = 3'd0; rd_ok = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; eng_flags = 6'h3F; ev_start_gen = 1'b1; ev_arb_lost = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 status in reset", status, 8'h00);
        rst_n = 1'b1; eng_flags = 6'h00; ev_start_gen = 1'b0; ev_arb_lost = 1'b0;
        cyc();
        chk("R2 status after reset", status, 8'h00);
    endtask

    task automatic t_master();
        ev_start_gen = 1'b1; cyc();
        chk("R3 start generated sets master", status, 8'h80);
        ev_stop_det = 1'b1; cyc();
        chk("R4 stop clears master", status, 8'h00);
        ev_start_gen = 1'b1; cyc();
        ev_exit = 1'b1; cyc();
        chk("R4 exit request clears master", status, 8'h00);
        ev_start_gen = 1'b1; cyc();
        ev_en_fall = 1'b1; cyc();
        chk("R4 enable fall clears master", status, 8'h00);
        ev_start_gen = 1'b1; ev_exit = 1'b1; cyc();
        chk("R4 clear beats set", status, 8'h00);
    endtask

    task automatic t_arb();
        ev_start_gen = 1'b1; cyc();
        ev_arb_lost = 1'b1; cyc();
        chk("R5 arbitration lost", status, 8'h40);
        rd_stb = 1'b1; rd_bit = 1'b0; rd_ok = 1'b0; cyc();
        chk("R8 byte read outside window", status, 8'h40);
        rd_stb = 1'b1; rd_bit = 1'b1; rd_sel = 3'd6; rd_ok = 1'b0; cyc();
        chk("R8 bit-6 read outside window", status, 8'h40);
        rd_stb = 1'b1; rd_bit = 1'b0; rd_ok = 1'b1; cyc();
        chk("R6 permitted byte read clears", status, 8'h00);
        ev_arb_lost = 1'b1; cyc();
        rd_stb = 1'b1; rd_bit = 1'b1; rd_sel = 3'd3; rd_ok = 1'b0; cyc();
        chk("R7 bit access to bit 3 clears", status, 8'h00);
        ev_arb_lost = 1'b1; rd_stb = 1'b1; rd_ok = 1'b1; cyc();
        chk("R6 set beats read clear", status, 8'h40);
        rd_stb = 1'b1; rd_bit = 1'b1; rd_sel = 3'd6; rd_ok = 1'b1; cyc();
        chk("R6 permitted bit-6 read clears", status, 8'h00);
        ev_arb_lost = 1'b1; cyc();
        ev_en_fall = 1'b1; cyc();
        chk("R6 enable fall clears", status, 8'h00);
    endtask

    task automatic t_capture();
        eng_flags = 6'h2A; ev_start_gen = 1'b1; cyc();
        chk("R1 bit order", status, 8'hAA);
        chk("R12 per-flag outputs",
            {flag_mst, flag_ald, flag_ext, flag_match,
             flag_xmit, flag_ack, flag_std, flag_spd}, 8'hAA);
        eng_flags = 6'h15; #1;
        chk("R9 no bypass path", status, 8'hAA);
        cyc();
        chk("R9 captured after one clock", status, 8'h95);
        eng_flags = 6'h00; ev_stop_det = 1'b1; cyc();
        chk("R9 cleared flags", status, 8'h00);
    endtask

    task automatic t_defer();
        wake_en = 1'b1; eng_flags = 6'h01; cyc();
        chk("R10 updates in wake mode", status, 8'h01);
        wake_en = 1'b0; eng_flags = 6'h02; cyc();
        chk("R10 update in the turn-off cycle", status, 8'h02);
        eng_flags = 6'h3C; ev_start_gen = 1'b1; cyc();
        chk("R10 frozen after start generated", status, 8'h02);
        cyc();
        chk("R10 still frozen", status, 8'h02);
        ev_start_det = 1'b1; cyc();
        chk("R11 released on start detect", status, 8'hBC);
        eng_flags = 6'h00; cyc();
        chk("R11 updates resume", status, 8'h80);
        ev_stop_det = 1'b1; cyc();
        chk("R11 stop clears master", status, 8'h00);
        wake_en = 1'b1; cyc();
        wake_en = 1'b0; cyc();
        eng_flags = 6'h07; ev_arb_lost = 1'b1; cyc();
        chk("R10 arbitration loss hidden", status, 8'h00);
        ev_stop_det = 1'b1; cyc();
        chk("R11 released on stop detect", status, 8'h47);
        eng_flags = 6'h00; rd_stb = 1'b1; rd_ok = 1'b1; cyc();
        chk("R11 live after release", status, 8'h00);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_master();
        t_arb();
        t_capture();
        t_defer();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule